// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block is the host-side engine for a serial dataflash that sits on a four-wire link: an active-low select, a serial clock whose idle level is low, a host-to-flash data line and a flash-to-host data line. A client hands it one command at a time over a valid/ready handshake. Each command carries an 8-bit command code, a 12-bit page number, a 9-bit byte offset and a data byte count. The sequencer then builds the serial frame for that command's class. Each class has its own arrangement of reserved bits, address bits and dummy bits. Write data is pulled from the client one byte at a time over a second handshake. Bytes returned by the flash are handed back on a one-cycle valid strobe.

All flash timing is counted on the system clock. One serial bit lasts a fixed number of system cycles. Select is held low with the clock idle for a minimum time before it rises, and it stays high for a minimum time between frames. After reset, nothing is sent until power has been good for a long lockout. The flash reset pin is then pulsed, and a short release lockout follows. A busy output covers initialisation, every frame and the guard time that trails it.

Top module: `sfseq_top`

## Requirements
- R1: Every frame sends its command code and then its address, dummy and data bits, each field most significant bit first, with `csN` held low from the first bit to the last.
- R2: Code 52h (main page read) sends 3 zero bits, the 12 page bits, the 9 offset bits and 32 zero dummy bits. It then shifts in `cmdLen` bytes from `miso` and returns each one on `rdData` with a one-cycle `rdValid`.
- R3: Codes 54h and 56h (buffer reads) send 15 zero bits, the 9 offset bits and 8 zero dummy bits, then return `cmdLen` bytes as in R2.
- R4: Codes 84h and 87h (buffer writes) send 15 zero bits and the 9 offset bits, then `cmdLen` bytes taken from `wrData`. `wrReady` is raised only while a write byte is awaited.
- R5: Codes 53h, 55h, 58h, 59h, 60h, 61h, 83h, 86h, 88h and 89h send 3 zero bits, the 12 page bits and 9 zero bits, with no data phase.
- R6: Codes 82h and 85h send 3 zero bits, the 12 page bits and the 9 offset bits, then `cmdLen` write bytes as in R4.
- R7: Code 57h (status poll) sends only the code, then returns `cmdLen` status bytes. Bit 7 of each byte is 1 for ready and 0 for busy.
- R8: Each serial bit lasts `BIT_CYCLES` system cycles. `sck` is low for the first `BIT_CYCLES/2` cycles and high for the rest. `mosi` does not change while `sck` is high, and `miso` is sampled in the last cycle of the bit.
- R9: Before `csN` rises, it stays low with `sck` low for at least `CS_GUARD` cycles. It then stays high for at least `CS_GUARD` cycles before the next fall.
- R10: After reset, `flashRstN` stays low and `cmdReady` stays low until `pwrGood` has been high for `PWR_LOCK` consecutive cycles. A drop of `pwrGood` restarts that count. `flashRstN` then stays low for `RST_PULSE` more cycles, and `cmdReady` rises `RST_LOCK` cycles after `flashRstN` rises.
- R11: `cmdReady` is high only when no frame, guard time or lockout is running. `busy` stays high through a frame and for at least `CS_GUARD` cycles after `csN` rises.
- R12: While `csN` is high, `sck` and `mosi` are low.
- R13: A command code outside R2 to R7 is accepted and dropped: `csN` does not fall and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pwrGood | input | 1 | Supply good indication |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Command taken this cycle when valid |
| cmdOp | input | 8 | Command code |
| cmdPage | input | 12 | Page number |
| cmdOffset | input | 9 | Byte offset in page or buffer |
| cmdLen | input | LEN_W | Data bytes to read or write |
| wrValid | input | 1 | Write byte offered |
| wrReady | output | 1 | Write byte taken this cycle when valid |
| wrData | input | 8 | Write byte |
| rdValid | output | 1 | Read byte strobe |
| rdData | output | 8 | Read byte |
| busy | output | 1 | Lockout, frame or guard time running |
| flashRstN | output | 1 | Active-low reset to the flash |
| csN | output | 1 | Active-low flash select |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |

## Verification
The bench keeps `BIT_CYCLES` at 5 and `CS_GUARD` at 13, so bit and guard timing are checked at their operating values. It shortens `PWR_LOCK` to 100, `RST_PULSE` to 20 and `RST_LOCK` to 10. With these values the complete power-up sequence, including a restart caused by a `pwrGood` glitch, can be measured cycle by cycle. A flash model captures every frame bit-for-bit and answers reads with known bytes. Commands are issued back to back, so a request is always pending while the guard intervals run.

// File: rtl/sfseq_pkg.sv
package sfseq_pkg;

  typedef enum logic [1:0] {DIR_NONE, DIR_READ, DIR_WRITE} dir_e;
  typedef enum logic [1:0] {ADR_NONE, ADR_FULL, ADR_BUF, ADR_PAGE} adr_e;

  typedef struct packed {
    logic       valid;
    logic [6:0] hdrBits;
    dir_e       dir;
    adr_e       adr;
  } cmd_class_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadHdr;
    logic loadByte;
    logic shiftBit;
    logic sampleBit;
    logic byteDone;
    logic csActive;
    logic sckHigh;
  } dp_strobe_t;

  function automatic cmd_class_t classify(input logic [7:0] op);
    cmd_class_t c;
    c = '{valid: 1'b1, hdrBits: 7'd32, dir: DIR_NONE, adr: ADR_PAGE};
    case (op)
      8'h52:             c = '{1'b1, 7'd64, DIR_READ,  ADR_FULL};
      8'h54, 8'h56:      c = '{1'b1, 7'd40, DIR_READ,  ADR_BUF};
      8'h84, 8'h87:      c = '{1'b1, 7'd32, DIR_WRITE, ADR_BUF};
      8'h82, 8'h85:      c = '{1'b1, 7'd32, DIR_WRITE, ADR_FULL};
      8'h57:             c = '{1'b1, 7'd8,  DIR_READ,  ADR_NONE};
      8'h53, 8'h55, 8'h58, 8'h59, 8'h60,
      8'h61, 8'h83, 8'h86, 8'h88, 8'h89: c = '{1'b1, 7'd32, DIR_NONE, ADR_PAGE};
      default:           c = '{1'b0, 7'd0,  DIR_NONE,  ADR_NONE};
    endcase
    return c;
  endfunction

  // Left-aligned header: code, 24 address bits, 32 dummy zeros
  function automatic logic [63:0] build_header(input logic [7:0] op,
                                               input logic [11:0] page,
                                               input logic [8:0] offset);
    logic [23:0] adr;
    case (classify(op).adr)
      ADR_FULL: adr = {3'b000, page, offset};
      ADR_BUF:  adr = {15'd0, offset};
      ADR_PAGE: adr = {3'b000, page, 9'd0};
      default:  adr = 24'd0;
    endcase
    return {op, adr, 32'd0};
  endfunction

endpackage

// File: rtl/sfseq_dp.sv
module sfseq_dp
  import sfseq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dp_strobe_t  stb,
  input  logic [63:0] hdrWord,
  input  logic [7:0]  wrData,
  input  logic        miso,
  output logic        csN,
  output logic        sck,
  output logic        mosi,
  output logic        rdValid,
  output logic [7:0]  rdData
);

  logic [63:0] txReg;
  logic [6:0]  rxReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg   <= '0;
      rxReg   <= '0;
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= 1'b0;
      if (stb.loadHdr)       txReg <= hdrWord;
      else if (stb.loadByte) txReg <= {wrData, 56'd0};
      else if (stb.shiftBit) txReg <= {txReg[62:0], 1'b0};
      if (stb.sampleBit) rxReg <= {rxReg[5:0], miso};
      if (stb.byteDone) begin
        rdValid <= 1'b1;
        rdData  <= {rxReg, miso};
      end
    end
  end

  assign csN  = ~stb.csActive;
  assign sck  = stb.sckHigh;
  assign mosi = stb.csActive & txReg[63];

  // R2: a returned byte always follows the sample of its last bit
  p_rd_follows_sample_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(stb.byteDone));

endmodule

// File: rtl/sfseq_ctrl.sv
module sfseq_ctrl
  import sfseq_pkg::*;
#(
  parameter int BIT_CYCLES = 5,
  parameter int CS_GUARD   = 13,
  parameter int PWR_LOCK   = 1000000,
  parameter int RST_PULSE  = 500,
  parameter int RST_LOCK   = 50,
  parameter int LEN_W      = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pwrGood,
  input  logic             cmdValid,
  input  logic [7:0]       cmdOp,
  input  logic [LEN_W-1:0] cmdLen,
  input  logic             wrValid,
  output logic             cmdReady,
  output logic             wrReady,
  output logic             busy,
  output logic             flashRstN,
  output dp_strobe_t       stb
);

  localparam int PH_W     = $clog2(BIT_CYCLES);
  localparam int SCK_RISE = BIT_CYCLES / 2;
  localparam int MAX_A    = (PWR_LOCK > RST_PULSE) ? PWR_LOCK : RST_PULSE;
  localparam int MAX_B    = (RST_LOCK > CS_GUARD) ? RST_LOCK : CS_GUARD;
  localparam int MAX_WAIT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);

  typedef enum logic [3:0] {
    S_PWR, S_RST, S_REL, S_IDLE, S_HDR, S_LOADW, S_DATA, S_TAIL, S_GAP
  } state_e;

  state_e           state;
  logic [CNT_W-1:0] waitCnt;
  logic [PH_W-1:0]  phase;
  logic [6:0]       bitsLeft;
  logic [2:0]       bitInByte;
  logic [LEN_W-1:0] bytesLeft;
  dir_e             dirR;
  cmd_class_t       cls;
  logic             bitEnd;
  logic             inBit;

  assign cls    = classify(cmdOp);
  assign bitEnd = (phase == PH_W'(BIT_CYCLES - 1));
  assign inBit  = (state == S_HDR) || (state == S_DATA);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_PWR;
      waitCnt   <= CNT_W'(PWR_LOCK - 1);
      phase     <= '0;
      bitsLeft  <= '0;
      bitInByte <= '0;
      bytesLeft <= '0;
      dirR      <= DIR_NONE;
    end else begin
      if (inBit) phase <= bitEnd ? '0 : phase + 1'b1;
      case (state)
        S_PWR: begin
          if (!pwrGood) waitCnt <= CNT_W'(PWR_LOCK - 1);
          else if (waitCnt == '0) begin
            state   <= S_RST;
            waitCnt <= CNT_W'(RST_PULSE - 1);
          end else waitCnt <= waitCnt - 1'b1;
        end
        S_RST: begin
          if (waitCnt == '0) begin
            state   <= S_REL;
            waitCnt <= CNT_W'(RST_LOCK - 1);
          end else waitCnt <= waitCnt - 1'b1;
        end
        S_REL, S_GAP: begin
          if (waitCnt == '0) state <= S_IDLE;
          else waitCnt <= waitCnt - 1'b1;
        end
        S_IDLE: begin
          if (cmdValid && cls.valid) begin
            state     <= S_HDR;
            phase     <= '0;
            bitsLeft  <= cls.hdrBits;
            dirR      <= cls.dir;
            bytesLeft <= (cls.dir == DIR_NONE) ? '0 : cmdLen;
          end
        end
        S_HDR: begin
          if (bitEnd) begin
            bitsLeft <= bitsLeft - 1'b1;
            if (bitsLeft == 7'd1) begin
              bitInByte <= '0;
              if (bytesLeft == '0) begin
                state   <= S_TAIL;
                waitCnt <= CNT_W'(CS_GUARD - 1);
              end else state <= (dirR == DIR_WRITE) ? S_LOADW : S_DATA;
            end
          end
        end
        S_LOADW: begin
          if (wrValid) begin
            state <= S_DATA;
            phase <= '0;
          end
        end
        S_DATA: begin
          if (bitEnd) begin
            bitInByte <= bitInByte + 1'b1;
            if (bitInByte == 3'd7) begin
              bytesLeft <= bytesLeft - 1'b1;
              if (bytesLeft == LEN_W'(1)) begin
                state   <= S_TAIL;
                waitCnt <= CNT_W'(CS_GUARD - 1);
              end else if (dirR == DIR_WRITE) state <= S_LOADW;
            end
          end
        end
        S_TAIL: begin
          if (waitCnt == '0) begin
            state   <= S_GAP;
            waitCnt <= CNT_W'(CS_GUARD - 1);
          end else waitCnt <= waitCnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb           = '0;
    stb.csActive  = (state == S_HDR) || (state == S_LOADW) ||
                    (state == S_DATA) || (state == S_TAIL);
    stb.sckHigh   = inBit && (phase >= PH_W'(SCK_RISE));
    stb.loadHdr   = (state == S_IDLE) && cmdValid && cls.valid;
    stb.loadByte  = (state == S_LOADW) && wrValid;
    stb.shiftBit  = inBit && bitEnd;
    stb.sampleBit = (state == S_DATA) && bitEnd && (dirR == DIR_READ);
    stb.byteDone  = stb.sampleBit && (bitInByte == 3'd7);
  end

  assign cmdReady  = (state == S_IDLE);
  assign wrReady   = (state == S_LOADW);
  assign busy      = (state != S_IDLE);
  assign flashRstN = !((state == S_PWR) || (state == S_RST));

  // R4: write bytes are only requested by a write-class frame
  p_wr_only_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrReady |-> (dirR == DIR_WRITE));

  // R11: a command is never offered a slot while select is active
  p_ready_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> !stb.csActive);

endmodule

// File: rtl/sfseq_top.sv
module sfseq_top
  import sfseq_pkg::*;
#(
  parameter int BIT_CYCLES = 5,
  parameter int CS_GUARD   = 13,
  parameter int PWR_LOCK   = 1000000,
  parameter int RST_PULSE  = 500,
  parameter int RST_LOCK   = 50,
  parameter int LEN_W      = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pwrGood,
  input  logic             cmdValid,
  output logic             cmdReady,
  input  logic [7:0]       cmdOp,
  input  logic [11:0]      cmdPage,
  input  logic [8:0]       cmdOffset,
  input  logic [LEN_W-1:0] cmdLen,
  input  logic             wrValid,
  output logic             wrReady,
  input  logic [7:0]       wrData,
  output logic             rdValid,
  output logic [7:0]       rdData,
  output logic             busy,
  output logic             flashRstN,
  output logic             csN,
  output logic             sck,
  output logic             mosi,
  input  logic             miso
);

  dp_strobe_t  stb;
  logic [63:0] hdrWord;

  assign hdrWord = build_header(cmdOp, cmdPage, cmdOffset);

  sfseq_ctrl #(
    .BIT_CYCLES(BIT_CYCLES), .CS_GUARD(CS_GUARD), .PWR_LOCK(PWR_LOCK),
    .RST_PULSE(RST_PULSE), .RST_LOCK(RST_LOCK), .LEN_W(LEN_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .cmdLen(cmdLen), .wrValid(wrValid),
    .cmdReady(cmdReady), .wrReady(wrReady), .busy(busy),
    .flashRstN(flashRstN), .stb(stb)
  );

  sfseq_dp i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .hdrWord(hdrWord), .wrData(wrData),
    .miso(miso), .csN(csN), .sck(sck), .mosi(mosi),
    .rdValid(rdValid), .rdData(rdData)
  );

  // run-length counters for the timing properties
  logic [31:0] csHighRun, quietRun, sckHiRun, rstLoRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csHighRun <= '0;
      quietRun  <= '0;
      sckHiRun  <= '0;
      rstLoRun  <= '0;
    end else begin
      csHighRun <= csN ? csHighRun + 1 : '0;
      quietRun  <= (!csN && !sck) ? quietRun + 1 : '0;
      sckHiRun  <= sck ? sckHiRun + 1 : '0;
      rstLoRun  <= !flashRstN ? rstLoRun + 1 : '0;
    end
  end

  p_gap_guard_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> (csHighRun >= 32'(CS_GUARD)));

  p_tail_guard_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> (quietRun >= 32'(CS_GUARD)));

  p_sck_high_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sck) |-> (sckHiRun == 32'(BIT_CYCLES - BIT_CYCLES / 2)));

  p_idle_lines_r12: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (!sck && !mosi));

  p_rst_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flashRstN) |-> (rstLoRun >= 32'(RST_PULSE)));

  p_quiet_in_reset_r10: assert property (@(posedge clk) disable iff (!rstN)
    !flashRstN |-> (csN && !cmdReady));

endmodule

// File: tb/test_sfseq_top.sv
module test_sfseq_top;

  localparam int BIT_CYCLES = 5;
  localparam int CS_GUARD   = 13;
  localparam int PWR_LOCK   = 100;
  localparam int RST_PULSE  = 20;
  localparam int RST_LOCK   = 10;
  localparam int LEN_W      = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0, pwrGood = 1'b0;
  logic cmdValid = 1'b0, cmdReady;
  logic [7:0] cmdOp = '0;
  logic [11:0] cmdPage = '0;
  logic [8:0] cmdOffset = '0;
  logic [LEN_W-1:0] cmdLen = '0;
  logic wrValid = 1'b0, wrReady;
  logic [7:0] wrData = '0;
  logic rdValid;
  logic [7:0] rdData;
  logic busy, flashRstN, csN, sck, mosi;
  logic miso = 1'b0;

  always #5 clk = ~clk;

  sfseq_top #(
    .BIT_CYCLES(BIT_CYCLES), .CS_GUARD(CS_GUARD), .PWR_LOCK(PWR_LOCK),
    .RST_PULSE(RST_PULSE), .RST_LOCK(RST_LOCK), .LEN_W(LEN_W)
  ) i_sfseq_top (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .cmdOp(cmdOp), .cmdPage(cmdPage),
    .cmdOffset(cmdOffset), .cmdLen(cmdLen), .wrValid(wrValid),
    .wrReady(wrReady), .wrData(wrData), .rdValid(rdValid), .rdData(rdData),
    .busy(busy), .flashRstN(flashRstN), .csN(csN), .sck(sck), .mosi(mosi),
    .miso(miso)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [127:0] bits;
    int           n;
    string        req;
  } frame_t;

  typedef struct {
    logic [7:0] val;
    string      req;
  } rbyte_t;

  frame_t expQ[$];
  rbyte_t rdQ[$];
  logic [7:0] statusVal = 8'h1C;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] resp_byte(input int k);
    return 8'h3C + 8'(k * 29);
  endfunction

  // ---------------- flash model: capture frames, answer reads
  int riseCnt = 0;
  int slaveHdr = 1000;
  logic [127:0] capBits;
  int capN;

  initial begin
    forever begin
      @(negedge csN);
      riseCnt = 0; capBits = '0; capN = 0; slaveHdr = 1000;
      forever begin
        @(posedge sck or posedge csN);
        if (csN) break;
        capBits = {capBits[126:0], mosi};
        capN++;
        riseCnt++;
        if (riseCnt == 8) begin
          case (capBits[7:0])
            8'h52: slaveHdr = 64;
            8'h54, 8'h56: slaveHdr = 40;
            8'h57: slaveHdr = 8;
            default: slaveHdr = 1000;
          endcase
        end
      end
      // R1: frame content compared against the scoreboard
      if (expQ.size() == 0) begin
        check(1'b0, "R13", "unexpected frame bits", capN, 0);
      end else begin
        frame_t e;
        e = expQ.pop_front();
        check(capN == e.n, e.req, "frame bit count", capN, e.n);
        check(capBits == e.bits, e.req, "frame content R1", capBits[63:0], e.bits[63:0]);
      end
    end
  end

  always @(negedge sck) begin
    if (!csN) begin
      #1;
      if (riseCnt >= slaveHdr) begin
        int b;
        b = riseCnt - slaveHdr;
        if (slaveHdr == 8) miso = statusVal[7 - (b % 8)];
        else begin
          logic [7:0] rb;
          rb = resp_byte(b / 8);
          miso = rb[7 - (b % 8)];
        end
      end
    end
  end

  // ---------------- read monitor
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (rdQ.size() == 0) check(1'b0, "R2", "unexpected read byte", rdData, 0);
      else begin
        rbyte_t r;
        r = rdQ.pop_front();
        check(rdData == r.val, r.req, "read byte", rdData, r.val);
      end
    end
  end

  // ---------------- timing monitor
  int csHigh = 0, quiet = 0, sckHi = 0, busyAfter = 0;
  logic prevCs = 1'b1, prevSck = 1'b0, prevMosi = 1'b0, prevBusy = 1'b1;
  always @(negedge clk) begin
    if (rstN) begin
      if (prevSck && !sck)
        check(sckHi == BIT_CYCLES - BIT_CYCLES / 2, "R8", "sck high width", sckHi,
              BIT_CYCLES - BIT_CYCLES / 2);
      if (prevSck && sck && mosi != prevMosi)
        check(1'b0, "R8", "mosi moved while sck high", mosi, prevMosi);
      if (prevCs && !csN) check(csHigh >= CS_GUARD, "R9", "select gap", csHigh, CS_GUARD);
      if (!prevCs && csN) check(quiet >= CS_GUARD, "R9", "select tail", quiet, CS_GUARD);
      if (csN && (sck || mosi)) check(1'b0, "R12", "lines active while deselected", {sck, mosi}, 0);
      if (!csN && (cmdReady || !busy)) check(1'b0, "R11", "ready/busy during frame", {cmdReady, busy}, 1);
      if (prevBusy && !busy && busyAfter > 0)
        check(busyAfter >= CS_GUARD, "R11", "busy after select rise", busyAfter, CS_GUARD);
      csHigh    = csN ? csHigh + 1 : 0;
      quiet     = (!csN && !sck) ? quiet + 1 : 0;
      sckHi     = sck ? sckHi + 1 : 0;
      busyAfter = !csN ? 0 : (busy ? busyAfter + 1 : 0);
      prevCs = csN; prevSck = sck; prevMosi = mosi; prevBusy = busy;
    end
  end

  // ---------------- driver
  task automatic do_cmd(input logic [7:0] op, input logic [11:0] pg,
                        input logic [8:0] off, input int len,
                        input logic [7:0] seed, input string req);
    logic [63:0] hdr;
    int n;
    int dir;  // 0 none, 1 read, 2 write
    frame_t f;
    n = 0; dir = 0; hdr = '0;
    case (op)
      8'h52: begin hdr = {op, 3'b0, pg, off, 32'h0, 13'h0}; n = 64; dir = 1; end
      8'h54, 8'h56: begin hdr = {op, 15'h0, off, 8'h0, 24'h0}; n = 40; dir = 1; end
      8'h84, 8'h87: begin hdr = {op, 15'h0, off, 32'h0}; n = 32; dir = 2; end
      8'h82, 8'h85: begin hdr = {op, 3'b0, pg, off, 32'h0}; n = 32; dir = 2; end
      8'h57: begin hdr = {op, 56'h0}; n = 8; dir = 1; end
      8'h53, 8'h55, 8'h58, 8'h59, 8'h60, 8'h61, 8'h83, 8'h86, 8'h88, 8'h89:
        begin hdr = {op, 3'b0, pg, 9'h0, 32'h0}; n = 32; dir = 0; end
      default: n = 0;
    endcase
    // 52h header: left-aligned 64 bits (the slice above is widened; rebuild exactly)
    if (op == 8'h52) hdr = {op, 3'b0, pg, off, 32'h0};
    if (n > 0) begin
      f.bits = '0; f.n = 0; f.req = req;
      for (int i = 63; i > 63 - n; i--) begin f.bits = {f.bits[126:0], hdr[i]}; f.n++; end
      if (dir != 0) begin
        for (int k = 0; k < len; k++) begin
          logic [7:0] d;
          d = (dir == 2) ? seed + 8'(k * 37) : 8'h00;
          for (int i = 7; i >= 0; i--) begin f.bits = {f.bits[126:0], d[i]}; f.n++; end
          if (dir == 1) begin
            rbyte_t r;
            r.val = (op == 8'h57) ? statusVal : resp_byte(k);
            r.req = req;
            rdQ.push_back(r);
          end
        end
      end
      expQ.push_back(f);
    end
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdPage = pg; cmdOffset = off; cmdLen = LEN_W'(len);
    while (!cmdReady) @(negedge clk);
    @(posedge clk); #1;
    cmdValid = 1'b0;
    if (dir == 2) begin
      for (int k = 0; k < len; k++) begin
        wrValid = 1'b1; wrData = seed + 8'(k * 37);
        while (!wrReady) @(negedge clk);
        @(posedge clk); #1;
        wrValid = 1'b0;
      end
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy || !csN) @(negedge clk);
  endtask

  // ---------------- watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- main sequence
  initial begin
    int cnt;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(csN == 1'b1 && flashRstN == 1'b0, "R10", "reset state select/flash reset", {csN, flashRstN}, 2'b10);
    check(cmdReady == 1'b0 && busy == 1'b1, "R11", "reset state ready/busy", {cmdReady, busy}, 2'b01);
    check(sck == 1'b0 && mosi == 1'b0, "R12", "reset state lines", {sck, mosi}, 0);
    repeat (30) @(negedge clk);
    check(flashRstN == 1'b0 && cmdReady == 1'b0, "R10", "held while power not good", {flashRstN, cmdReady}, 0);
    // power good glitch restarts the lockout count
    pwrGood = 1'b1;
    repeat (50) @(negedge clk);
    pwrGood = 1'b0;
    @(negedge clk);
    pwrGood = 1'b1;
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!flashRstN);
    check(cnt == PWR_LOCK + RST_PULSE, "R10", "cycles to flash reset release", cnt, PWR_LOCK + RST_PULSE);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!cmdReady);
    check(cnt == RST_LOCK, "R10", "release lockout", cnt, RST_LOCK);

    // R7 status poll: busy then ready
    statusVal = 8'h1C;
    do_cmd(8'h57, 12'h000, 9'h000, 1, 8'h00, "R7");
    wait_idle();
    check(rdData[7] == 1'b0, "R7", "status busy bit", rdData[7], 0);
    statusVal = 8'h9C;
    do_cmd(8'h57, 12'h000, 9'h000, 2, 8'h00, "R7");
    wait_idle();
    check(rdData[7] == 1'b1, "R7", "status ready bit", rdData[7], 1);

    // back-to-back commands (no idle wait between)
    do_cmd(8'h52, 12'hA53, 9'h1FF, 3, 8'h00, "R2");
    do_cmd(8'h52, 12'h001, 9'h000, 1, 8'h00, "R2");
    do_cmd(8'h54, 12'hFFF, 9'h10A, 2, 8'h00, "R3");
    do_cmd(8'h56, 12'h000, 9'h001, 1, 8'h00, "R3");
    do_cmd(8'h84, 12'hFFF, 9'h005, 4, 8'hC3, "R4");
    do_cmd(8'h87, 12'h000, 9'h1AA, 1, 8'h5A, "R4");
    do_cmd(8'h53, 12'h9A5, 9'h1FF, 0, 8'h00, "R5");
    do_cmd(8'h60, 12'h001, 9'h0F0, 0, 8'h00, "R5");
    do_cmd(8'h83, 12'hFFE, 9'h000, 3, 8'h00, "R5");
    do_cmd(8'h88, 12'h7C1, 9'h155, 0, 8'h00, "R5");
    do_cmd(8'h59, 12'h800, 9'h001, 0, 8'h00, "R5");
    do_cmd(8'h82, 12'h3C3, 9'h0A9, 2, 8'h81, "R6");
    do_cmd(8'h85, 12'hFFF, 9'h1FF, 1, 8'hFF, "R6");
    wait_idle();

    // R13 unknown codes are dropped
    do_cmd(8'hFF, 12'h123, 9'h045, 2, 8'h00, "R13");
    @(negedge clk);
    check(busy == 1'b0 && csN == 1'b1, "R13", "no frame after unknown code", {busy, csN}, 2'b01);
    do_cmd(8'h00, 12'h000, 9'h000, 0, 8'h00, "R13");
    repeat (20) @(negedge clk);
    check(busy == 1'b0 && csN == 1'b1, "R13", "still idle after unknown code", {busy, csN}, 2'b01);

    // read with zero length: header only
    do_cmd(8'h54, 12'h000, 9'h0C3, 0, 8'h00, "R3");
    wait_idle();

    repeat (5) @(negedge clk);
    check(expQ.size() == 0, "R1", "frames outstanding", expQ.size(), 0);
    check(rdQ.size() == 0, "R2", "read bytes outstanding", rdQ.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule